// File: doc/BRIEF.md
# Audio Transmit FIFO Register Front-End

This block is the register and buffering side of a serial audio output controller. A host writes 32-bit words on a simple word-addressed bus. It programs a configuration register and an interrupt mask, and it pushes sample words into a transmit FIFO. One word goes to one channel slot, so two pushes make one stereo frame. The serializer downstream takes the configuration fields, the FIFO head word and the empty flag, and it pops words with a single strobe. Serial bit timing and clock generation belong to that serializer and are not part of this block.

Two conditions are computed every cycle from the live FIFO occupancy. The first is "starved", which means the FIFO is empty. The second is "low", which means the occupancy is below a programmable threshold. The threshold is half the FIFO depth shifted right by a 4-bit level field. Both conditions are readable as status bits. Each can be routed to the single interrupt line through a mask bit. A global interrupt enable in the configuration register gates the line.

There is no sequencing state in this block. Every bus access completes in one cycle, and a read returns its data one cycle after the request. The only state is the FIFO pointers and count, the configuration register, the mask register and the registered read data.

Top module: `atx_fifo_regs`

## Requirements
- R1: After reset, the configuration register (index 1, byte 0x04) and the mask register (index 2, byte 0x08) read 0. The identity register (index 0, byte 0x00) reads the VERSION parameter. irq is 0 and fifo_empty is 1.
- R2: A write to the configuration register keeps only these fields, which read back as written and drive the outputs: bit 0 transmit enable, bit 1 interrupt enable, bits 15:8 rate ratio, bits 21:16 sample resolution, bits 27:24 level, bits 31:28 channel field. All other bits read 0.
- R3: A write to any of byte addresses 0x10, 0x14, 0x18 or 0x1C pushes the 32-bit write data into the FIFO. Words come out on fifo_rd_data in write order. Each fifo_rd_en pulse pops one word while the FIFO is not empty.
- R4: Status bit 0 (starved, at index 3, byte 0x0C) is 1 exactly when the FIFO holds no words, and it always equals fifo_empty.
- R5: Status bit 1 (low) is 1 exactly when occupancy < (DEPTH/2) >> level. Status bits 31:2 read 0.
- R6: A push while the FIFO holds DEPTH words is discarded. Occupancy and stored contents do not change.
- R7: irq is 1 exactly when the interrupt enable bit is 1 and (status AND mask bits 1:0) is nonzero. Mask bits 31:2 read 0.
- R8: Writes to the status register and to the identity register have no effect on any register or on irq.
- R9: Reads of the four channel-data addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address, word-aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| tx_enable | output | 1 | Configuration transmit enable |
| rate_ratio | output | 8 | Configuration rate ratio |
| sample_res | output | 6 | Configuration sample resolution |
| chan_field | output | 4 | Configuration channel field |
| fifo_rd_en | input | 1 | Pop strobe from the serializer |
| fifo_rd_data | output | 32 | FIFO head word |
| fifo_empty | output | 1 | FIFO holds no words |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences cover a small FIFO in four ways. It is filled to full and then over-pushed, which separates a correct discard from a wrap that overwrites the oldest word. It is drained to empty with extra pops. It is swept through every level value, including values whose threshold reaches zero. Every mask and enable combination is tried with the FIFO empty, with it low, and with it above the threshold, so that each interrupt source is seen in isolation. A seeded random mix of pushes to all four data addresses, pops, level changes and mask changes then compares the status, irq and popped data against a queue model after every operation. This catches an off-by-one in the threshold compare and any reordering of words.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int REG_IDX_W = 3;
    localparam logic [REG_IDX_W-1:0] IDX_IDENT = 3'd0;
    localparam logic [REG_IDX_W-1:0] IDX_CONFIG = 3'd1;
    localparam logic [REG_IDX_W-1:0] IDX_MASK = 3'd2;
    localparam logic [REG_IDX_W-1:0] IDX_STATUS = 3'd3;

    localparam int CF_TXEN = 0;
    localparam int CF_IEN = 1;
    localparam int CF_RATIO_LO = 8;
    localparam int CF_RES_LO = 16;
    localparam int CF_LVL_LO = 24;
    localparam int CF_CHAN_LO = 28;
    localparam logic [31:0] CF_KEEP = 32'hFF3F_FF03;

    localparam int ST_STARVED = 0;
    localparam int ST_LOW = 1;
    localparam int ST_W = 2;
endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
    parameter int DEPTH = 1024,
    parameter int DW = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic [AW:0]   occupancy
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty = (occupancy == '0);
    assign full = (occupancy == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop = pop && !empty;
    assign head = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            occupancy <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10: occupancy <= occupancy + 1'b1;
                2'b01: occupancy <= occupancy - 1'b1;
                default: occupancy <= occupancy;
            endcase
        end
    end
endmodule

// File: rtl/atx_status.sv
module atx_status
    import atx_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW:0]     occupancy,
    input  logic [3:0]      level,
    input  logic [ST_W-1:0] mask,
    input  logic            int_en,
    output logic [ST_W-1:0] sts,
    output logic            irq
);
    localparam logic [AW:0] HALF = (AW+1)'(DEPTH/2);
    logic [AW:0] threshold;

    always_comb begin
        threshold = HALF >> level;
        sts = '0;
        sts[ST_STARVED] = (occupancy == '0);
        sts[ST_LOW] = (occupancy < threshold);
        irq = int_en && |(sts & mask);
    end
endmodule

// File: rtl/atx_regs.sv
module atx_regs
    import atx_pkg::*;
#(
    parameter logic [31:0] VERSION = 32'h0001_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [31:0]          wdata,
    input  logic [ST_W-1:0]      sts,
    output logic [31:0]          cfg_q,
    output logic [ST_W-1:0]      mask_q,
    output logic [31:0]          rdata
);
    logic [31:0] rd_mux;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            mask_q <= '0;
        end else if (wr) begin
            if (idx == IDX_CONFIG) cfg_q <= wdata & CF_KEEP;
            if (idx == IDX_MASK) mask_q <= wdata[ST_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (idx)
            IDX_IDENT: rd_mux = VERSION;
            IDX_CONFIG: rd_mux = cfg_q;
            IDX_MASK: rd_mux = {{(32-ST_W){1'b0}}, mask_q};
            IDX_STATUS: rd_mux = {{(32-ST_W){1'b0}}, sts};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end
endmodule

// File: rtl/atx_fifo_regs.sv
module atx_fifo_regs
    import atx_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter logic [31:0] VERSION = 32'h0001_0000,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_enable,
    output logic [7:0]  rate_ratio,
    output logic [5:0]  sample_res,
    output logic [3:0]  chan_field,
    input  logic        fifo_rd_en,
    output logic [31:0] fifo_rd_data,
    output logic        fifo_empty,
    output logic        irq
);
    logic [REG_IDX_W-1:0] idx;
    logic [31:0]          cfg_q;
    logic [ST_W-1:0]      mask_q, sts;
    logic [AW:0]          occupancy;
    logic                 full, push, int_en;

    assign idx = bus_addr[4:2];
    assign push = bus_wr && idx[2];
    assign int_en = cfg_q[CF_IEN];
    assign tx_enable = cfg_q[CF_TXEN];
    assign rate_ratio = cfg_q[CF_RATIO_LO +: 8];
    assign sample_res = cfg_q[CF_RES_LO +: 6];
    assign chan_field = cfg_q[CF_CHAN_LO +: 4];

    atx_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(bus_wdata),
        .pop(fifo_rd_en), .head(fifo_rd_data), .empty(fifo_empty),
        .full(full), .occupancy(occupancy)
    );

    atx_status #(.DEPTH(DEPTH)) u_status (
        .occupancy(occupancy), .level(cfg_q[CF_LVL_LO +: 4]),
        .mask(mask_q), .int_en(int_en), .sts(sts), .irq(irq)
    );

    atx_regs #(.VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .idx(idx),
        .wdata(bus_wdata), .sts(sts), .cfg_q(cfg_q), .mask_q(mask_q),
        .rdata(bus_rdata)
    );
endmodule

// File: rtl/atx_fifo_regs_chk.sv
module atx_fifo_regs_chk #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        push,
    input logic        fifo_rd_en,
    input logic [AW:0] occupancy,
    input logic        full,
    input logic        fifo_empty,
    input logic [1:0]  sts,
    input logic        int_en,
    input logic        irq,
    input logic        bus_wr,
    input logic [2:0]  idx,
    input logic [31:0] cfg_q
);
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= (AW+1)'(DEPTH));
    // R6
    full_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !fifo_rd_en) |=> $stable(occupancy));
    // R3
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && push && !fifo_rd_en) |=> occupancy == $past(occupancy) + 1'b1);
    // R4
    starved_is_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts[0] == fifo_empty);
    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> int_en);
    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && idx == 3'd1) |=> $stable(cfg_q));
endmodule

bind atx_fifo_regs atx_fifo_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .fifo_rd_en(fifo_rd_en),
    .occupancy(occupancy), .full(full), .fifo_empty(fifo_empty), .sts(sts),
    .int_en(int_en), .irq(irq), .bus_wr(bus_wr), .idx(idx), .cfg_q(cfg_q)
);

// File: tb/atx_fifo_regs_tb.sv
module atx_fifo_regs_tb;
    localparam int DEPTH = 16;
    localparam logic [31:0] VER = 32'hA5C3_0102;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, bus_rd = 0, fifo_rd_en = 0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, fifo_rd_data;
    logic tx_enable, fifo_empty, irq;
    logic [7:0] rate_ratio;
    logic [5:0] sample_res;
    logic [3:0] chan_field;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] model[$];
    logic [3:0] m_lvl = 0;
    logic [1:0] m_mask = 0;
    logic m_ien = 0;
    logic [31:0] rd_val;

    always #10 clk = ~clk;

    atx_fifo_regs #(.DEPTH(DEPTH), .VERSION(VER)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        if (a[4] && model.size() < DEPTH) model.push_back(d);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic pop_chk(input string req);
        @(negedge clk);
        if (model.size() > 0) chk(req, fifo_rd_data, model[0]);
        fifo_rd_en = 1;
        @(negedge clk);
        fifo_rd_en = 0;
        if (model.size() > 0) void'(model.pop_front());
    endtask

    function automatic logic [1:0] exp_sts();
        int thr = (DEPTH / 2) >> m_lvl;
        return {model.size() < thr, model.size() == 0};
    endfunction

    function automatic logic exp_irq();
        return m_ien && |(exp_sts() & m_mask);
    endfunction

    task automatic set_cfg(input logic [3:0] lvl, input logic ien);
        m_lvl = lvl; m_ien = ien;
        wr(5'h04, {4'h0, lvl, 22'h0, ien, 1'b0});
    endtask

    task automatic status_chk(input string req);
        rd(5'h0C, rd_val);
        chk(req, rd_val, {30'h0, exp_sts()});
        chk({req, " irq R7"}, {31'h0, irq}, {31'h0, exp_irq()});
        chk({req, " empty R4"}, {31'h0, fifo_empty}, {31'h0, model.size() == 0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(5'h04, rd_val); chk("R1 cfg", rd_val, 32'h0);
        rd(5'h08, rd_val); chk("R1 mask", rd_val, 32'h0);
        rd(5'h00, rd_val); chk("R1 version", rd_val, VER);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 empty", {31'h0, fifo_empty}, 32'h1);
        // R2 field filter and outputs
        wr(5'h04, 32'hFFFF_FFFE);
        rd(5'h04, rd_val); chk("R2 cfg readback", rd_val, 32'hFF3F_FF02);
        chk("R2 outputs", {tx_enable, rate_ratio, sample_res, chan_field}, {1'b0, 8'hFF, 6'h3F, 4'hF});
        wr(5'h04, 32'h5A15_A301);
        chk("R2 outputs b", {tx_enable, rate_ratio, sample_res, chan_field}, {1'b1, 8'hA3, 6'h15, 4'h5});
        set_cfg(4'h0, 1'b0);
        // R8 writes to status and identity ignored
        wr(5'h0C, 32'hFFFF_FFFF); wr(5'h00, 32'h0);
        rd(5'h00, rd_val); chk("R8 version", rd_val, VER);
        rd(5'h04, rd_val); chk("R8 cfg", rd_val, 32'h0);
        rd(5'h08, rd_val); chk("R8 mask", rd_val, 32'h0);
        status_chk("R8 status");
        // R7 mask upper bits
        wr(5'h08, 32'hFFFF_FFFF); m_mask = 2'b11;
        rd(5'h08, rd_val); chk("R7 mask read", rd_val, 32'h3);
        chk("R7 no enable", {31'h0, irq}, 32'h0);
        // R9 data addresses read 0 and R3 pushes on all four
        for (int i = 0; i < 4; i++) wr(5'h10 + 5'(i * 4), 32'hC0DE_0000 + i);
        for (int i = 0; i < 4; i++) begin
            rd(5'h10 + 5'(i * 4), rd_val); chk("R9 data read", rd_val, 32'h0);
        end
        status_chk("R5 four words");
        // R6 fill and over-push
        while (model.size() < DEPTH) wr(5'h14, $urandom);
        wr(5'h18, 32'hDEAD_BEEF); wr(5'h1C, 32'hBAD0_BAD0);
        status_chk("R6 full");
        for (int i = 0; i < DEPTH; i++) pop_chk("R6 R3 order after overfill");
        status_chk("R4 drained");
        pop_chk("R4 extra pop");
        status_chk("R4 still empty");
        // R5 level sweep and R7 sources one at a time
        for (int lv = 0; lv < 16; lv++) begin
            set_cfg(4'(lv), 1'b1);
            for (int m = 0; m < 4; m++) begin
                wr(5'h08, 32'(m)); m_mask = 2'(m);
                status_chk("R5 R7 sweep");
            end
            wr(5'h10, $urandom);
            wr(5'h10, $urandom);
            status_chk("R5 sweep two more");
        end
        while (model.size() > 0) pop_chk("R3 sweep drain");
        // random mix
        for (int it = 0; it < 600; it++) begin
            int op = $urandom_range(0, 9);
            if (op < 5) wr(5'h10 + 5'($urandom_range(0, 3) * 4), $urandom);
            else if (op < 8) pop_chk("R3 random pop");
            else if (op == 8) set_cfg(4'($urandom_range(0, 5)), 1'($urandom_range(0, 1)));
            else begin
                m_mask = 2'($urandom_range(0, 3));
                wr(5'h08, {30'h0, m_mask});
            end
            status_chk("R5 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule